// File: doc/BRIEF.md
# Five-Port Mesh Router Node with X-First Routing

This block is one node of a two-dimensional mesh network-on-chip. It has four neighbour links and one link to the local processing module. Every packet is a single flit. A flit holds a channel tag, which the node carries through without using it, a destination coordinate pair and a payload. Each input link writes arriving flits into its own small queue. Only the head flit of each queue competes for the crossbar.

The node compares the head flit's destination with its own coordinates, which are parameters. It moves the flit along X until the X coordinate matches, then along Y, and hands it to the local module when both match. Each output link has its own rotating-priority arbiter. A flit may leave only while the receiving queue downstream does not report full. A blocked head flit holds up every flit queued behind it.

Top module: `meshRouter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every outValid bit and every inFull bit is low.
- R2: Port indices are Local=0, North=1, East=2, South=3, West=4. A head flit whose destination X is greater than the node X leaves on East. One whose destination X is less than the node X leaves on West.
- R3: A head flit whose destination X equals the node X leaves on South when destination Y is greater than node Y, and on North when it is less. No flit leaves on North or South while its X differs from the node X.
- R4: A flit addressed to the node's own coordinates leaves on the Local port.
- R5: The flit layout is {tag[VC_W], dstY[YW], dstX[XW], payload[PAY_W]}, with the payload in the low bits. The flit leaves bit-for-bit unchanged, and the tag has no effect on the port chosen.
- R6: outValid of a port never rises while downFull of that port is high. The waiting flit leaves in the first cycle after downFull falls.
- R7: A blocked head flit holds back every later flit of the same input, even a flit bound for a free output. Flits of one input leave in arrival order.
- R8: inFull of an input is high exactly while its queue holds FIFO_DEPTH flits.
- R9: Each output grants among requesting inputs in rotating order. The search starts at the input after the last winner, and the first search after reset starts at index 0.
- R10: Each output carries at most one flit per cycle. Flits bound for different outputs leave in the same cycle.
- R11: A flit written at a clock edge into an empty queue, with an uncontested and non-full output, is presented on that output during the cycle that follows the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 5 | Per input link: a flit is offered this cycle |
| inFlit | input | 5 x FLIT_W | Per input link: offered flit |
| inFull | output | 5 | Per input link: the local queue is full |
| outValid | output | 5 | Per output link: a flit is transferred this cycle |
| outFlit | output | 5 x FLIT_W | Per output link: transferred flit |
| downFull | input | 5 | Per output link: the downstream queue is full |

## Verification
A wrong route decision or a corrupted queue pointer shows up in the very cycle the flit reaches the queue head. The flit appears on the wrong port, or with a wrong payload, or in the wrong order relative to its predecessors. A stuck or mis-rotated arbiter pointer shows up only under contention, as a wrong winner sequence across consecutive cycles on one output. A fault in the back-pressure path shows up as a transfer while downFull is high, or as a flit that does not leave in the cycle right after downFull falls.

// File: rtl/meshRouterPkg.sv
package meshRouterPkg;
  localparam int PORTS = 5;

  typedef enum logic [2:0] {
    PORT_LOCAL = 3'd0,
    PORT_NORTH = 3'd1,
    PORT_EAST  = 3'd2,
    PORT_SOUTH = 3'd3,
    PORT_WEST  = 3'd4
  } portId_t;

  // Strobes from control to datapath: sel[out] is a one-hot input select,
  // pop[in] retires the head flit of that input queue.
  typedef struct packed {
    logic [PORTS-1:0][PORTS-1:0] sel;
    logic [PORTS-1:0]            pop;
  } xbarStrobe_t;
endpackage

// File: rtl/routerDp.sv
module routerDp
  import meshRouterPkg::*;
#(
  parameter int FLIT_W = 22,
  parameter int DEPTH  = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [PORTS-1:0]              inValid,
  input  logic [PORTS-1:0][FLIT_W-1:0]  inFlit,
  input  xbarStrobe_t                   strobe,
  output logic [PORTS-1:0]              inFull,
  output logic [PORTS-1:0]              headValid,
  output logic [PORTS-1:0][FLIT_W-1:0]  headFlit,
  output logic [PORTS-1:0]              outValid,
  output logic [PORTS-1:0][FLIT_W-1:0]  outFlit
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  for (genvar i = 0; i < PORTS; i++) begin : g_queue
    logic [FLIT_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  rdPtr, wrPtr;
    logic [CNT_W-1:0]  count;
    logic              push, pop;

    assign push = inValid[i] && (count != FULL);
    assign pop  = strobe.pop[i];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rdPtr <= '0;
        wrPtr <= '0;
        count <= '0;
      end else begin
        if (push) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
        if (pop)  rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
        if (push && !pop)      count <= count + 1'b1;
        else if (pop && !push) count <= count - 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (push) mem[wrPtr] <= inFlit[i];
    end

    assign inFull[i]    = (count == FULL);
    assign headValid[i] = (count != '0);
    assign headFlit[i]  = mem[rdPtr];
  end

  always_comb begin
    for (int o = 0; o < PORTS; o++) begin
      outValid[o] = |strobe.sel[o];
      outFlit[o]  = '0;
      for (int i = 0; i < PORTS; i++) begin
        if (strobe.sel[o][i]) outFlit[o] = outFlit[o] | headFlit[i];
      end
    end
  end
endmodule

// File: rtl/routerCtl.sv
module routerCtl
  import meshRouterPkg::*;
#(
  parameter int XW     = 2,
  parameter int YW     = 2,
  parameter int NODE_X = 1,
  parameter int NODE_Y = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [PORTS-1:0]          headValid,
  input  logic [PORTS-1:0][XW-1:0]  headDstX,
  input  logic [PORTS-1:0][YW-1:0]  headDstY,
  input  logic [PORTS-1:0]          downFull,
  output xbarStrobe_t               strobe
);
  localparam logic [XW-1:0] MY_X = XW'(NODE_X);
  localparam logic [YW-1:0] MY_Y = YW'(NODE_Y);

  portId_t routeSel [PORTS];

  for (genvar i = 0; i < PORTS; i++) begin : g_route
    always_comb begin
      if (headDstX[i] > MY_X)      routeSel[i] = PORT_EAST;
      else if (headDstX[i] < MY_X) routeSel[i] = PORT_WEST;
      else if (headDstY[i] > MY_Y) routeSel[i] = PORT_SOUTH;
      else if (headDstY[i] < MY_Y) routeSel[i] = PORT_NORTH;
      else                         routeSel[i] = PORT_LOCAL;
    end
  end

  for (genvar o = 0; o < PORTS; o++) begin : g_arb
    logic [2:0]       lastWin;
    logic [PORTS-1:0] req;
    logic [PORTS-1:0] gnt;
    logic [2:0]       winIdx;

    always_comb begin
      for (int i = 0; i < PORTS; i++) begin
        req[i] = headValid[i] && (routeSel[i] == portId_t'(o)) && !downFull[o];
      end
    end

    always_comb begin
      gnt    = '0;
      winIdx = lastWin;
      for (int off = PORTS; off >= 1; off--) begin
        int idx;
        idx = (int'(lastWin) + off) % PORTS;
        if (req[idx]) begin
          gnt    = '0;
          gnt[idx] = 1'b1;
          winIdx = 3'(idx);
        end
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)     lastWin <= 3'(PORTS - 1);
      else if (|gnt) lastWin <= winIdx;
    end

    assign strobe.sel[o] = gnt;
  end

  always_comb begin
    strobe.pop = '0;
    for (int o = 0; o < PORTS; o++) strobe.pop = strobe.pop | strobe.sel[o];
  end
endmodule

// File: rtl/meshRouter.sv
module meshRouter
  import meshRouterPkg::*;
#(
  parameter int MESH_W     = 4,
  parameter int MESH_H     = 4,
  parameter int NODE_X     = 1,
  parameter int NODE_Y     = 2,
  parameter int PAY_W      = 16,
  parameter int VC_W       = 2,
  parameter int FIFO_DEPTH = 4,
  localparam int XW        = (MESH_W > 1) ? $clog2(MESH_W) : 1,
  localparam int YW        = (MESH_H > 1) ? $clog2(MESH_H) : 1,
  localparam int FLIT_W    = VC_W + YW + XW + PAY_W
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [4:0]                    inValid,
  input  logic [4:0][FLIT_W-1:0]        inFlit,
  output logic [4:0]                    inFull,
  output logic [4:0]                    outValid,
  output logic [4:0][FLIT_W-1:0]        outFlit,
  input  logic [4:0]                    downFull
);
  xbarStrobe_t                  strobe;
  logic [PORTS-1:0]             headValid;
  logic [PORTS-1:0][FLIT_W-1:0] headFlit;
  logic [PORTS-1:0][XW-1:0]     headDstX;
  logic [PORTS-1:0][YW-1:0]     headDstY;

  for (genvar i = 0; i < PORTS; i++) begin : g_field
    assign headDstX[i] = headFlit[i][PAY_W +: XW];
    assign headDstY[i] = headFlit[i][PAY_W + XW +: YW];
  end

  routerDp #(.FLIT_W(FLIT_W), .DEPTH(FIFO_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inFlit(inFlit),
    .strobe(strobe), .inFull(inFull), .headValid(headValid),
    .headFlit(headFlit), .outValid(outValid), .outFlit(outFlit)
  );

  routerCtl #(.XW(XW), .YW(YW), .NODE_X(NODE_X), .NODE_Y(NODE_Y)) u_ctl (
    .clk(clk), .rstN(rstN), .headValid(headValid), .headDstX(headDstX),
    .headDstY(headDstY), .downFull(downFull), .strobe(strobe)
  );
endmodule

// File: rtl/meshRouterChk.sv
module meshRouterChk
  import meshRouterPkg::*;
#(
  parameter int XW     = 2,
  parameter int YW     = 2,
  parameter int PAY_W  = 16,
  parameter int FLIT_W = 22,
  parameter int NODE_X = 1,
  parameter int NODE_Y = 2
) (
  input logic                         clk,
  input logic                         rstN,
  input logic [4:0]                   inFull,
  input logic [4:0]                   outValid,
  input logic [4:0][FLIT_W-1:0]       outFlit,
  input logic [4:0]                   downFull,
  input xbarStrobe_t                  strobe
);
  localparam logic [XW-1:0] MY_X = XW'(NODE_X);
  localparam logic [YW-1:0] MY_Y = YW'(NODE_Y);

  AST_RESET_QUIET: assert property (@(posedge clk) !rstN |=> (inFull == '0)); // R1
  AST_NO_SEND_WHEN_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (outValid & downFull) == '0); // R6
  AST_EAST_X_GREATER: assert property (@(posedge clk) disable iff (!rstN)
    outValid[2] |-> (outFlit[2][PAY_W +: XW] > MY_X)); // R2
  AST_WEST_X_LESS: assert property (@(posedge clk) disable iff (!rstN)
    outValid[4] |-> (outFlit[4][PAY_W +: XW] < MY_X)); // R2
  AST_Y_AFTER_X: assert property (@(posedge clk) disable iff (!rstN)
    (outValid[1] || outValid[3]) |->
      ((!outValid[1] || outFlit[1][PAY_W +: XW] == MY_X) &&
       (!outValid[3] || outFlit[3][PAY_W +: XW] == MY_X))); // R3
  AST_LOCAL_OWN: assert property (@(posedge clk) disable iff (!rstN)
    outValid[0] |-> (outFlit[0][PAY_W +: XW] == MY_X &&
                     outFlit[0][PAY_W + XW +: YW] == MY_Y)); // R4
  AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe.sel[0]) && $onehot0(strobe.sel[1]) && $onehot0(strobe.sel[2]) &&
    $onehot0(strobe.sel[3]) && $onehot0(strobe.sel[4])); // R10
endmodule

bind meshRouter meshRouterChk #(
  .XW(XW), .YW(YW), .PAY_W(PAY_W), .FLIT_W(FLIT_W),
  .NODE_X(NODE_X), .NODE_Y(NODE_Y)
) u_chk (
  .clk(clk), .rstN(rstN), .inFull(inFull), .outValid(outValid),
  .outFlit(outFlit), .downFull(downFull), .strobe(strobe)
);

// File: tb/meshRouter_tb.sv
module meshRouter_tb;
  localparam int FW = 22;
  localparam int DEPTH = 4;
  localparam logic [15:0] VEC [10] = '{
    16'h4322, 16'h0024, 16'h1133, 16'h3101, 16'h2120,
    16'h0302, 16'h1034, 16'h4111, 16'h3232, 16'h2133 };

  logic clk = 0, rstN = 0;
  logic [4:0] inValid = '0, downFull = '0, inFull, outValid;
  logic [4:0][FW-1:0] inFlit = '0;
  logic [4:0][FW-1:0] outFlit;
  int nChk = 0, nBad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  meshRouter u_dut (.clk(clk), .rstN(rstN), .inValid(inValid), .inFlit(inFlit),
    .inFull(inFull), .outValid(outValid), .outFlit(outFlit), .downFull(downFull));

  function automatic logic [FW-1:0] mk(int x, int y, int vc, int pay);
    return {2'(vc), 2'(y), 2'(x), 16'(pay)};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      nChk++; nBad++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 outValid in reset", 64'(outValid), 0);
    chk("R1 inFull in reset", 64'(inFull), 0);
    rstN = 1;
    @(negedge clk);
    chk("R1 outValid after reset", 64'(outValid), 0);
    chk("R1 inFull after reset", 64'(inFull), 0);

    // Vector table: R2 R3 R4 R5 R11
    for (int j = 0; j < 10; j++) begin
      int ip, ex;
      logic [FW-1:0] f;
      ip = int'(VEC[j][15:12]); ex = int'(VEC[j][3:0]);
      f = mk(int'(VEC[j][11:8]), int'(VEC[j][7:4]), j % 4, 'hA000 + j * 'h111);
      inFlit[ip] = f; inValid[ip] = 1'b1;
      @(negedge clk);
      inValid = '0;
      chk("R2/R3/R4 port select", 64'(outValid), 64'(5'b1 << ex));
      chk("R5 flit unchanged", 64'(outFlit[ex]), 64'(f));
      @(negedge clk);
      chk("R11 single transfer", 64'(outValid), 0);
    end

    // R10 concurrent transfers to distinct outputs
    inFlit[4] = mk(3, 2, 1, 'h1111); inFlit[2] = mk(0, 2, 2, 'h2222);
    inFlit[0] = mk(1, 0, 3, 'h3333); inValid = 5'b10101;
    @(negedge clk);
    inValid = '0;
    chk("R10 parallel valid", 64'(outValid), 64'(5'b10110));
    chk("R10 east flit", 64'(outFlit[2]), 64'(mk(3, 2, 1, 'h1111)));
    chk("R10 west flit", 64'(outFlit[4]), 64'(mk(0, 2, 2, 'h2222)));
    chk("R10 north flit", 64'(outFlit[1]), 64'(mk(1, 0, 3, 'h3333)));
    @(negedge clk);

    // R6 R7 R8 back-pressure and head-of-line blocking on West input
    downFull[2] = 1'b1;
    for (int k = 0; k < DEPTH; k++) begin
      inFlit[4] = (k == 0) ? mk(3, 2, 0, 'hB000) : mk(1, 2, 0, 'hB000 + k);
      inValid[4] = 1'b1;
      @(negedge clk);
      inValid = '0;
      chk("R6 no east while full", 64'(outValid[2]), 0);
      chk("R7 local held behind head", 64'(outValid[0]), 0);
      chk("R8 inFull level", 64'(inFull[4]), 64'(k == DEPTH - 1));
    end
    repeat (2) @(negedge clk);
    chk("R7 still blocked", 64'(outValid), 0);
    downFull[2] = 1'b0;
    #1;
    chk("R6 release east", 64'(outValid[2]), 1);
    chk("R6 release flit", 64'(outFlit[2]), 64'(mk(3, 2, 0, 'hB000)));
    for (int k = 1; k < DEPTH; k++) begin
      @(negedge clk); #1;
      chk("R8 full drops", 64'(inFull[4]), 0);
      chk("R7 order valid", 64'(outValid[0]), 1);
      chk("R7 order payload", 64'(outFlit[0][15:0]), 64'('hB000 + k));
    end
    @(negedge clk);

    // R9 round robin: L,N,S,W all bound east, two rounds
    downFull[2] = 1'b1;
    for (int r = 0; r < 2; r++) begin
      for (int p = 0; p < 5; p++) inFlit[p] = mk(3, (p == 1) ? 1 : 3, 0, 'hC000 + r * 16 + p);
      inValid = 5'b11011;
      @(negedge clk);
    end
    inValid = '0;
    chk("R6 contention held", 64'(outValid[2]), 0);
    downFull[2] = 1'b0;
    for (int r = 0; r < 2; r++) begin
      foreach (VEC[q]) begin end
      for (int s = 0; s < 4; s++) begin
        int p;
        p = (s < 2) ? s : s + 1;
        #1;
        chk("R9 winner order", 64'(outFlit[2][15:0]), 64'('hC000 + r * 16 + p));
        chk("R10 one per cycle", 64'(outValid), 64'(5'b00100));
        @(negedge clk);
      end
    end
    chk("R9 drained", 64'(outValid), 0);

    finished = 1;
    summary();
  end
endmodule